// File: doc/BRIEF.md
# USB Endpoint Control and Status Register

This block is the control and status word of one endpoint in a full-speed USB device controller. Firmware reaches it over a simple register port: one write strobe with a data word, and a read word that always shows the current flags. On the other side, the serial interface engine reports one-cycle strobes. These cover an IN token arriving, the host acknowledging a data packet, and a CRC failure on an isochronous packet. For each IN token the block returns the handshake the engine must send.

The word holds four flags, and they do not share one ownership rule. Transmit-ready is set by firmware and cleared by the controller once the host has acknowledged the payload. Firmware may withdraw it only while no payload is on the wire. Transmit-complete and the isochronous error flag are raised by the controller. Firmware clears them by writing 0, and a write of 1 to them does nothing. Force-stall belongs to firmware alone and overrides every other answer. The interrupt line follows the two controller-raised flags. A short busy window after each firmware change of transmit-ready tells firmware to keep off the data path.

Top module: `usb_ep_csr`

## Requirements
- R1: After reset all four flags read 0, and `irq`, `busy` and `hs_valid` are 0.
- R2: The read word carries transmit-ready at bit 0, transmit-complete at bit 1, force-stall at bit 2 and isochronous error at bit 3. All higher bits read 0. Force-stall reads back the last value firmware wrote to bit 2.
- R3: A write with bit 0 = 1 sets transmit-ready. When the host then acknowledges a payload that was answered with DATA, transmit-ready clears and transmit-complete sets.
- R4: One cycle after an `in_tok` strobe, `hs_valid` is 1 for one cycle. `hs_code` is then 2'b11 (STALL) if force-stall was 1. Otherwise it is 2'b01 (DATA) if transmit-ready was 1. Otherwise it is 2'b10 (NAK).
- R5: A write with bit 0 = 0 clears transmit-ready when no DATA answer is awaiting acknowledgement. While one is awaiting acknowledgement, that write leaves transmit-ready at 1.
- R6: A write with a bit = 0 clears transmit-complete (bit 1) or isochronous error (bit 3). A write with that bit = 1 leaves the flag unchanged.
- R7: An `iso_crc_err` strobe sets the isochronous error flag.
- R8: When a controller set event and a firmware clear of the same flag fall in one cycle, the flag ends at 1.
- R9: `irq` is 1 exactly while transmit-complete or isochronous error is 1. It falls in the cycle after the last of them is cleared.
- R10: After a firmware write changes transmit-ready, `busy` is 1 for exactly 3 cycles. A write that leaves transmit-ready unchanged does not raise `busy`.
- R11: An `ack_rcv` strobe with no DATA answer awaiting acknowledgement changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Firmware write strobe |
| wdata | input | DATA_W | Firmware write word |
| rdata | output | DATA_W | Current register contents |
| in_tok | input | 1 | IN token strobe from the serial engine |
| ack_rcv | input | 1 | Host acknowledge strobe from the serial engine |
| iso_crc_err | input | 1 | Isochronous CRC failure strobe |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake: 01 DATA, 10 NAK, 11 STALL |
| irq | output | 1 | Endpoint interrupt |
| busy | output | 1 | Data path settling after a transmit-ready change |

## Verification
The assertions assume that the engine strobes are single-cycle pulses. They also assume that `in_tok` and `ack_rcv` never fall in the same cycle, and that every strobe, like `wr_en`, is low while reset is held. The bench drives each strobe for exactly one cycle from a task. It drives inputs on the falling edge, keeps token and acknowledge strobes in separate cycles, and releases reset with all inputs at 0. Collision cases pair a firmware write only with a controller event, never with a second engine strobe.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  localparam int FIELD_W    = 4;
  localparam int TXRDY_BIT  = 0;
  localparam int TXDONE_BIT = 1;
  localparam int STALL_BIT  = 2;
  localparam int ISOERR_BIT = 3;

  typedef enum logic [1:0] {
    HS_DATA  = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;

  typedef struct packed {
    logic isoerr;
    logic stall;
    logic txdone;
    logic txrdy;
  } ep_flags_t;

  // Handshake choice for an IN token: stall first, then data, else nak.
  function automatic hs_code_e pick_handshake(input logic stall, input logic txrdy);
    if (stall)      return HS_STALL;
    else if (txrdy) return HS_DATA;
    else            return HS_NAK;
  endfunction

endpackage

// File: rtl/ep_flags.sv
module ep_flags
  import usb_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [FIELD_W-1:0] wfield,
  input  logic       ack_done,
  input  logic       crc_err,
  input  logic       in_flight,
  output ep_flags_t  flags,
  output logic       fw_txrdy_evt
);

  ep_flags_t q;

  logic wr_set_txrdy, wr_cancel, wr_clr_done, wr_clr_err;

  always_comb begin
    wr_set_txrdy = wr_en &  wfield[TXRDY_BIT];
    wr_cancel    = wr_en & ~wfield[TXRDY_BIT] & q.txrdy & ~in_flight;
    wr_clr_done  = wr_en & ~wfield[TXDONE_BIT];
    wr_clr_err   = wr_en & ~wfield[ISOERR_BIT];
    fw_txrdy_evt = (wr_set_txrdy & ~q.txrdy) | (wr_cancel & ~ack_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      // transmit-ready: new payload wins over completion, completion over cancel
      if (wr_set_txrdy)     q.txrdy <= 1'b1;
      else if (ack_done)    q.txrdy <= 1'b0;
      else if (wr_cancel)   q.txrdy <= 1'b0;

      // controller-raised flags: set beats firmware clear
      if (ack_done)         q.txdone <= 1'b1;
      else if (wr_clr_done) q.txdone <= 1'b0;

      if (crc_err)          q.isoerr <= 1'b1;
      else if (wr_clr_err)  q.isoerr <= 1'b0;

      if (wr_en)            q.stall <= wfield[STALL_BIT];
    end
  end

  assign flags = q;

endmodule

// File: rtl/ep_handshake.sv
module ep_handshake
  import usb_ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_tok,
  input  logic     ack_rcv,
  input  logic     stall,
  input  logic     txrdy,
  output logic     hs_valid,
  output hs_code_e hs_code,
  output logic     in_flight,
  output logic     ack_done
);

  hs_code_e choice;

  always_comb begin
    choice   = pick_handshake(stall, txrdy);
    ack_done = ack_rcv & in_flight & ~in_tok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid  <= 1'b0;
      hs_code   <= HS_NAK;
      in_flight <= 1'b0;
    end else begin
      hs_valid <= in_tok;
      if (in_tok) begin
        hs_code   <= choice;
        in_flight <= (choice == HS_DATA);
      end else if (ack_rcv) begin
        in_flight <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ep_settle.sv
module ep_settle #(
  parameter int BUSY_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (trigger)      cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/usb_ep_csr.sv
module usb_ep_csr
  import usb_ep_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              in_tok,
  input  logic              ack_rcv,
  input  logic              iso_crc_err,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              irq,
  output logic              busy
);

  ep_flags_t flags;
  hs_code_e  hs_code_q;
  logic      in_flight, ack_done, fw_txrdy_evt;
  logic      wdata_unused;

  assign wdata_unused = ^wdata;

  ep_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wfield       (wdata[FIELD_W-1:0]),
    .ack_done     (ack_done),
    .crc_err      (iso_crc_err),
    .in_flight    (in_flight),
    .flags        (flags),
    .fw_txrdy_evt (fw_txrdy_evt)
  );

  ep_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tok    (in_tok),
    .ack_rcv   (ack_rcv),
    .stall     (flags.stall),
    .txrdy     (flags.txrdy),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code_q),
    .in_flight (in_flight),
    .ack_done  (ack_done)
  );

  ep_settle #(.BUSY_CYCLES(BUSY_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (fw_txrdy_evt),
    .busy    (busy)
  );

  always_comb begin
    rdata = '0;
    rdata[FIELD_W-1:0] = flags;
  end

  assign hs_code = hs_code_q;
  assign irq     = flags.txdone | flags.isoerr;

endmodule

// File: rtl/ep_csr_checker.sv
module ep_csr_checker
  import usb_ep_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              in_tok,
  input logic              ack_rcv,
  input logic              iso_crc_err,
  input logic              hs_valid,
  input logic [1:0]        hs_code,
  input logic              irq,
  input logic              busy,
  input logic              in_flight,
  input logic              fw_txrdy_evt
);

  p_stall_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok && rdata[STALL_BIT] |=> hs_valid && hs_code == 2'b11);

  p_data_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok && !rdata[STALL_BIT] && rdata[TXRDY_BIT] |=> hs_valid && hs_code == 2'b01);

  p_nak_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok && !rdata[STALL_BIT] && !rdata[TXRDY_BIT] |=> hs_valid && hs_code == 2'b10);

  p_hs_after_tok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tok |=> !hs_valid);

  p_iso_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iso_crc_err |=> rdata[ISOERR_BIT]);

  p_err_w1_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata[ISOERR_BIT] && rdata[ISOERR_BIT] |=> rdata[ISOERR_BIT]);

  p_cancel_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wdata[TXRDY_BIT] && in_flight && !ack_rcv |=> rdata[TXRDY_BIT]);

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rcv && !in_flight && !wr_en && !iso_crc_err && !in_tok |=> $stable(rdata));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fw_txrdy_evt |=> busy);

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> FIELD_W) == '0);

endmodule

bind usb_ep_csr ep_csr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wdata        (wdata),
  .rdata        (rdata),
  .in_tok       (in_tok),
  .ack_rcv      (ack_rcv),
  .iso_crc_err  (iso_crc_err),
  .hs_valid     (hs_valid),
  .hs_code      (hs_code),
  .irq          (irq),
  .busy         (busy),
  .in_flight    (in_flight),
  .fw_txrdy_evt (fw_txrdy_evt)
);

// File: tb/tb_usb_ep_csr.sv
`timescale 1ns/1ps
module tb_usb_ep_csr;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          in_tok = 1'b0, ack_rcv = 1'b0, iso_crc_err = 1'b0;
  logic          hs_valid, irq, busy;
  logic [1:0]    hs_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_ep_csr #(.DATA_W(DW), .BUSY_CYCLES(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .in_tok(in_tok), .ack_rcv(ack_rcv), .iso_crc_err(iso_crc_err),
    .hs_valid(hs_valid), .hs_code(hs_code), .irq(irq), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, hold one cycle, return at the next falling edge
  task automatic step(input logic we, input logic [DW-1:0] d,
                      input logic tok, input logic ack, input logic crc);
    wr_en = we; wdata = d; in_tok = tok; ack_rcv = ack; iso_crc_err = crc;
    @(negedge clk);
    wr_en = 0; wdata = '0; in_tok = 0; ack_rcv = 0; iso_crc_err = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // read word helper: bit0 ready, bit1 complete, bit2 stall, bit3 error
  function automatic logic [DW-1:0] word(input logic err, input logic st,
                                          input logic dn, input logic rdy);
    return {{(DW-4){1'b0}}, err, st, dn, rdy};
  endfunction

  task automatic do_reset();
    rst_n = 0; idle(2); rst_n = 1; idle(1);
  endtask

  task automatic t_reset();
    check("R1 rdata", int'(rdata), 0);
    check("R1 irq/busy/hs_valid", {irq, busy, hs_valid}, 0);
  endtask

  task automatic t_layout();
    step(1, 8'hF4, 0, 0, 0);             // stall=1, upper bits written as 1
    check("R2 stall readback, upper zero", int'(rdata), int'(word(0, 1, 0, 0)));
    step(1, 8'h0A, 0, 0, 0);             // stall=0
    check("R2 stall cleared", int'(rdata), 0);
  endtask

  task automatic t_nak_empty();
    step(0, '0, 1, 0, 0);
    check("R4 nak valid", hs_valid, 1);
    check("R4 nak code", hs_code, 2'b10);
    idle(1);
    check("R4 hs_valid one cycle", hs_valid, 0);
  endtask

  task automatic t_data_path();
    step(1, 8'h0B, 0, 0, 0);             // set ready, keep sticky bits
    check("R3 ready set", int'(rdata), int'(word(0, 0, 0, 1)));
    idle(3);
    step(0, '0, 1, 0, 0);
    check("R4 data code", hs_code, 2'b01);
    step(0, '0, 0, 1, 0);
    check("R3 ack clears ready sets complete", int'(rdata), int'(word(0, 0, 1, 0)));
    check("R9 irq with complete", irq, 1);
    step(1, 8'h08, 0, 0, 0);             // clear complete
    check("R9 irq falls after clear", irq, 0);
    idle(3);
  endtask

  task automatic t_cancel();
    step(1, 8'h0B, 0, 0, 0);
    idle(3);
    step(1, 8'h0A, 0, 0, 0);             // bit0=0 with nothing in flight
    check("R5 cancel clears ready", int'(rdata[0]), 0);
    idle(3);
  endtask

  task automatic t_cancel_inflight();
    step(1, 8'h0B, 0, 0, 0);
    idle(3);
    step(0, '0, 1, 0, 0);                // DATA answered
    step(1, 8'h0A, 0, 0, 0);             // cancel attempt while awaiting ack
    check("R5 cancel ignored in flight", int'(rdata[0]), 1);
    check("R10 no busy on unchanged ready", busy, 0);
    step(0, '0, 0, 1, 0);
    check("R3 ack after blocked cancel", int'(rdata), int'(word(0, 0, 1, 0)));
    step(1, 8'h08, 0, 0, 0);
    idle(3);
  endtask

  task automatic t_stall();
    step(1, 8'h0F, 0, 0, 0);             // ready and stall together
    idle(3);
    step(0, '0, 1, 0, 0);
    check("R4 stall wins over data", hs_code, 2'b11);
    step(1, 8'h0B, 0, 0, 0);             // stall off
    step(0, '0, 1, 0, 0);
    check("R4 data after stall released", hs_code, 2'b01);
    step(0, '0, 0, 1, 0);
    step(1, 8'h08, 0, 0, 0);
    idle(3);
  endtask

  task automatic t_w1_noeffect();
    step(0, '0, 0, 0, 1);
    check("R7 crc sets error", int'(rdata), int'(word(1, 0, 0, 0)));
    step(1, 8'h08, 0, 0, 0);             // write 1 to error
    check("R6 write 1 keeps error", int'(rdata[3]), 1);
    step(1, 8'h00, 0, 0, 0);
    check("R6 write 0 clears error", int'(rdata[3]), 0);
    check("R9 irq low", irq, 0);
  endtask

  task automatic t_collision();
    step(1, 8'h00, 0, 0, 1);             // clear write + crc in same cycle
    check("R8 crc wins over clear", int'(rdata[3]), 1);
    step(1, 8'h01, 0, 0, 0);             // ready set, error cleared
    idle(3);
    step(0, '0, 1, 0, 0);
    step(1, 8'h01, 0, 1, 0);             // ack + clear complete, keep ready
    check("R8 ack wins over complete clear", int'(rdata[1]), 1);
    step(1, 8'h08, 0, 0, 0);
    idle(3);
  endtask

  task automatic t_busy();
    step(1, 8'h0B, 0, 0, 0);
    check("R10 busy cycle 1", busy, 1);
    idle(1); check("R10 busy cycle 2", busy, 1);
    idle(1); check("R10 busy cycle 3", busy, 1);
    idle(1); check("R10 busy ends", busy, 0);
    step(1, 8'h0B, 0, 0, 0);             // ready already 1
    check("R10 no busy on same value", busy, 0);
    step(1, 8'h0A, 0, 0, 0);
    idle(3);
  endtask

  task automatic t_stray_ack();
    step(1, 8'h0B, 0, 0, 0);
    idle(3);
    step(0, '0, 0, 1, 0);                // no DATA answered yet
    check("R11 stray ack ignored", int'(rdata), int'(word(0, 0, 0, 1)));
    check("R11 no irq", irq, 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_layout();
    t_nak_empty();
    t_data_path();
    t_cancel();
    t_cancel_inflight();
    t_stall();
    t_w1_noeffect();
    t_collision();
    t_busy();
    t_stray_ack();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule